// File: doc/BRIEF.md
# Streaming Header Extractor and Filter

This block sits on a byte-wide packet stream that carries one byte per clock, with a valid qualifier and marks for the first and last byte of each packet. It collects the first `HDR_BYTES` bytes of every packet in a shift register. When the last of those bytes arrives, it presents the whole header as a single wide beat. That way, downstream logic sees every header field at once, not one field per cycle.

A comparator checks one field of the header against a match value supplied as a configuration input. The result goes out together with the header beat and also decides what happens to the rest of the packet. For a passing packet, the header is stripped and the payload bytes are forwarded with their own valid, start and end marks. For a failing packet, every byte up to its end mark is discarded. A packet that ends before its header is complete is dropped, and a saturating runt counter is incremented.

Top module: `hdr_filter_top`

## Requirements
- R1: While reset is held and after it is released, the header valid, payload valid, payload start and payload end outputs are low and the runt count is zero.
- R2: The header beat is valid for exactly one cycle, one cycle after the clock that accepted the `HDR_BYTES`-th byte of a packet. Its most significant byte lane holds the first byte received and its least significant lane holds the last.
- R3: The match flag reported with the header beat is 1 exactly when the `FLD_BYTES` header bytes starting at byte position `FLD_OFS` equal `cfg_match_i`. Position 0 is the first received byte, and the earliest field byte is compared with the most significant byte of `cfg_match_i`. Bytes outside the field have no effect on the flag.
- R4: For a passing packet, each byte after the header appears on the payload output one cycle after it is accepted. The payload start mark is set on the first payload byte only, and no header byte ever appears on the payload output.
- R5: The payload end mark is set on the same beat as the payload byte that carried the input end mark, and on no other beat.
- R6: For a failing packet, no byte after the header appears on the payload output. This holds through the packet's end mark.
- R7: A packet whose end mark comes before its `HDR_BYTES`-th byte (a single-byte packet with both marks included) produces no header beat and no payload. It raises the runt count by one, one cycle after its last byte. The count saturates at its all-ones value.
- R8: Valid bytes that arrive after a packet's end mark and before the next start mark produce no output and do not change the runt count.
- R9: A start mark arriving in the middle of a packet abandons that packet and begins header collection again at the marked byte.
- R10: A packet exactly `HDR_BYTES` long produces its header beat and no payload beat.
- R11: Cycles with valid low may fall anywhere inside a packet. They are not counted as bytes and do not disturb the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte qualifier |
| in_sop_i | input | 1 | First byte of a packet |
| in_eop_i | input | 1 | Last byte of a packet |
| in_data_i | input | 8 | Input byte |
| cfg_match_i | input | FLD_BYTES*8 | Value the header field must equal |
| hdr_valid_o | output | 1 | Wide header beat present |
| hdr_data_o | output | HDR_BYTES*8 | Gathered header, first byte in top lane |
| hdr_pass_o | output | 1 | Field match result for the last header beat |
| pay_valid_o | output | 1 | Payload byte present |
| pay_sop_o | output | 1 | First payload byte of a packet |
| pay_eop_o | output | 1 | Last payload byte of a packet |
| pay_data_o | output | 8 | Payload byte |
| runt_cnt_o | output | RUNT_W | Saturating count of packets too short for a header |

## Verification
The bench runs four kinds of traffic.
- A matching packet with back-to-back bytes shows header alignment, stripping and mark placement.
- A packet that differs only inside the field, and another that differs only outside it, tell apart a comparator looking at the right byte lanes from one looking at the wrong ones.
- Bursts with idle gaps in both the header and the payload show that only qualified bytes are counted.
- Runts, stray bytes between packets, restarts in mid-packet and a packet exactly one header long exercise the state transitions and the saturating counter, with enough runts to reach saturation.

// File: rtl/hdr_filter_pkg.sv
package hdr_filter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_PASS,
    ST_DROP
  } flt_state_e;
endpackage

// File: rtl/hdr_shift.sv
module hdr_shift #(
  parameter int HDR_BYTES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   beat_i,
  input  logic                   start_i,
  input  logic [7:0]             data_i,
  output logic [HDR_BYTES*8-1:0] hdr_q_o,
  output logic [HDR_BYTES*8-1:0] hdr_nxt_o,
  output logic                   last_o
);
  localparam int HW = HDR_BYTES * 8;
  localparam int CW = $clog2(HDR_BYTES + 1);

  logic [HW-1:0] hdr_q;
  logic [CW-1:0] cnt_q;

  assign hdr_nxt_o = {hdr_q[HW-9:0], data_i};
  assign hdr_q_o   = hdr_q;
  // next header byte (not a start byte) completes the header
  assign last_o    = (cnt_q == CW'(HDR_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q <= '0;
      cnt_q <= '0;
    end else if (beat_i) begin
      hdr_q <= hdr_nxt_o;
      cnt_q <= start_i ? CW'(1) : cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(HDR_BYTES)); // R2
endmodule

// File: rtl/fld_cmp.sv
module fld_cmp #(
  parameter int HDR_BYTES = 8,
  parameter int FLD_OFS   = 2,
  parameter int FLD_BYTES = 2
) (
  input  logic [HDR_BYTES*8-1:0] hdr_i,
  input  logic [FLD_BYTES*8-1:0] ref_i,
  output logic                   hit_o
);
  localparam int TOP = (HDR_BYTES - FLD_OFS) * 8;
  localparam int FW  = FLD_BYTES * 8;

  logic [FLD_BYTES-1:0] lane_eq;
  logic                 unused_bits;

  for (genvar i = 0; i < FLD_BYTES; i++) begin : g_lane
    assign lane_eq[i] = (hdr_i[TOP-1-8*i -: 8] == ref_i[FW-1-8*i -: 8]);
  end

  assign hit_o       = &lane_eq;
  assign unused_bits = ^hdr_i;
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (inc_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_RUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_o == $past(cnt_o) + 1'b1) || (&cnt_o)); // R7
  AST_RUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o)); // R8
endmodule

// File: rtl/hdr_filter_top.sv
module hdr_filter_top #(
  parameter int HDR_BYTES = 8,
  parameter int FLD_OFS   = 2,
  parameter int FLD_BYTES = 2,
  parameter int RUNT_W    = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic                   in_sop_i,
  input  logic                   in_eop_i,
  input  logic [7:0]             in_data_i,
  input  logic [FLD_BYTES*8-1:0] cfg_match_i,
  output logic                   hdr_valid_o,
  output logic [HDR_BYTES*8-1:0] hdr_data_o,
  output logic                   hdr_pass_o,
  output logic                   pay_valid_o,
  output logic                   pay_sop_o,
  output logic                   pay_eop_o,
  output logic [7:0]             pay_data_o,
  output logic [RUNT_W-1:0]      runt_cnt_o
);
  import hdr_filter_pkg::*;

  localparam int HW = HDR_BYTES * 8;

  flt_state_e    st_q, st_d;
  logic          beat, start, last, hit, fire, runt_inc, pay_emit;
  logic [HW-1:0] hdr_nxt;
  logic          hdr_vld_q, hdr_pass_q, first_q;
  logic          pay_vld_q, pay_sop_q, pay_eop_q;
  logic [7:0]    pay_data_q;

  hdr_shift #(.HDR_BYTES(HDR_BYTES)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (beat),
    .start_i   (start),
    .data_i    (in_data_i),
    .hdr_q_o   (hdr_data_o),
    .hdr_nxt_o (hdr_nxt),
    .last_o    (last)
  );

  fld_cmp #(
    .HDR_BYTES (HDR_BYTES),
    .FLD_OFS   (FLD_OFS),
    .FLD_BYTES (FLD_BYTES)
  ) u_cmp (
    .hdr_i (hdr_nxt),
    .ref_i (cfg_match_i),
    .hit_o (hit)
  );

  sat_cnt #(.W(RUNT_W)) u_runt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (runt_inc),
    .cnt_o  (runt_cnt_o)
  );

  always_comb begin
    st_d     = st_q;
    beat     = 1'b0;
    start    = 1'b0;
    fire     = 1'b0;
    runt_inc = 1'b0;
    pay_emit = 1'b0;
    if (in_valid_i) begin
      if (in_sop_i) begin
        beat  = 1'b1;
        start = 1'b1;
        if (in_eop_i) begin
          runt_inc = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          st_d = ST_HDR;
        end
      end else begin
        unique case (st_q)
          ST_HDR: begin
            beat = 1'b1;
            if (last) begin
              fire = 1'b1;
              st_d = in_eop_i ? ST_IDLE : (hit ? ST_PASS : ST_DROP);
            end else if (in_eop_i) begin
              runt_inc = 1'b1;
              st_d     = ST_IDLE;
            end
          end
          ST_PASS: begin
            pay_emit = 1'b1;
            if (in_eop_i) st_d = ST_IDLE;
          end
          ST_DROP: if (in_eop_i) st_d = ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      hdr_vld_q  <= 1'b0;
      hdr_pass_q <= 1'b0;
      first_q    <= 1'b0;
      pay_vld_q  <= 1'b0;
      pay_sop_q  <= 1'b0;
      pay_eop_q  <= 1'b0;
      pay_data_q <= '0;
    end else begin
      st_q      <= st_d;
      hdr_vld_q <= fire;
      pay_vld_q <= pay_emit;
      pay_sop_q <= pay_emit & first_q;
      pay_eop_q <= pay_emit & in_eop_i;
      if (fire)          hdr_pass_q <= hit;
      if (fire)          first_q    <= 1'b1;
      else if (pay_emit) first_q    <= 1'b0;
      if (pay_emit)      pay_data_q <= in_data_i;
    end
  end

  assign hdr_valid_o = hdr_vld_q;
  assign hdr_pass_o  = hdr_pass_q;
  assign pay_valid_o = pay_vld_q;
  assign pay_sop_o   = pay_sop_q;
  assign pay_eop_o   = pay_eop_q;
  assign pay_data_o  = pay_data_q;

  AST_HDR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_q |=> !hdr_vld_q); // R2
  AST_HDR_FROM_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_q |-> $past(in_valid_i)); // R2
  AST_PAY_NEEDS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_vld_q |-> hdr_pass_q); // R6
  AST_PAY_FROM_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_vld_q |-> $past(in_valid_i && !in_sop_i) && pay_data_q == $past(in_data_i)); // R4
  AST_SOP_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_sop_q |-> pay_vld_q); // R4
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_vld_q && pay_vld_q)); // R4
  AST_EOP_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_eop_q |-> pay_vld_q && $past(in_eop_i)); // R5
endmodule

// File: tb/hdr_filter_top_test.sv
module hdr_filter_top_test;
  localparam int HB = 6;
  localparam int FO = 2;
  localparam int FB = 2;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic            in_valid, in_sop, in_eop;
  logic [7:0]      in_data;
  logic [FB*8-1:0] cfg;
  logic            hdr_valid, hdr_pass, pay_valid, pay_sop, pay_eop;
  logic [HB*8-1:0] hdr_data;
  logic [7:0]      pay_data;
  logic [RW-1:0]   runt_cnt;

  hdr_filter_top #(.HDR_BYTES(HB), .FLD_OFS(FO), .FLD_BYTES(FB), .RUNT_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_sop_i(in_sop),
    .in_eop_i(in_eop), .in_data_i(in_data), .cfg_match_i(cfg),
    .hdr_valid_o(hdr_valid), .hdr_data_o(hdr_data), .hdr_pass_o(hdr_pass),
    .pay_valid_o(pay_valid), .pay_sop_o(pay_sop), .pay_eop_o(pay_eop),
    .pay_data_o(pay_data), .runt_cnt_o(runt_cnt)
  );

  int    total = 0, bad = 0;
  string cur_req = "R1";

  // reference model state
  int              m_st = 0;   // 0 idle, 1 header, 2 pass, 3 drop
  logic [7:0]      m_q[$];
  int              m_runt = 0;
  logic            m_first = 0;
  logic            e_hv = 0, e_hp = 0, e_pv = 0, e_ps = 0, e_pe = 0;
  logic [HB*8-1:0] e_hd = '0;
  logic [7:0]      e_pd = '0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("hdr_valid", 64'(hdr_valid), 64'(e_hv));
    if (e_hv) begin
      chk("hdr_data", 64'(hdr_data), 64'(e_hd));
      chk("hdr_pass", 64'(hdr_pass), 64'(e_hp));
    end
    chk("pay_valid", 64'(pay_valid), 64'(e_pv));
    if (e_pv) begin
      chk("pay_sop", 64'(pay_sop), 64'(e_ps));
      chk("pay_eop", 64'(pay_eop), 64'(e_pe));
      chk("pay_data", 64'(pay_data), 64'(e_pd));
    end else begin
      chk("pay_sop_idle", 64'(pay_sop), 64'(0));
      chk("pay_eop_idle", 64'(pay_eop), 64'(0));
    end
    chk("runt_cnt", 64'(runt_cnt), 64'(m_runt));
  endtask

  task automatic model_step(bit v, bit s, bit e, logic [7:0] d);
    logic [HB*8-1:0] h;
    logic [FB*8-1:0] f;
    e_hv = 0; e_pv = 0; e_ps = 0; e_pe = 0;
    if (!v) return;
    if (s) begin
      m_q = {d};
      if (e) begin
        if (m_runt < (1 << RW) - 1) m_runt++;
        m_st = 0;
      end else m_st = 1;
    end else if (m_st == 1) begin
      m_q.push_back(d);
      if (m_q.size() == HB) begin
        h = '0;
        foreach (m_q[i]) h = {h[HB*8-9:0], m_q[i]};
        f = '0;
        for (int k = 0; k < FB; k++) f = {f[FB*8-9:0], m_q[FO+k]};
        e_hv = 1; e_hd = h; e_hp = (f == cfg);
        m_first = 1;
        m_st = e ? 0 : (e_hp ? 2 : 3);
      end else if (e) begin
        if (m_runt < (1 << RW) - 1) m_runt++;
        m_st = 0;
      end
    end else if (m_st == 2) begin
      e_pv = 1; e_pd = d; e_ps = m_first; e_pe = e;
      m_first = 0;
      if (e) m_st = 0;
    end else if (m_st == 3) begin
      if (e) m_st = 0;
    end
  endtask

  task automatic drive(bit v, bit s, bit e, logic [7:0] d);
    in_valid = v; in_sop = s; in_eop = e; in_data = d;
    model_step(v, s, e, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic pkt(logic [7:0] b[$], int gap);
    foreach (b[i]) begin
      drive(1, i == 0, i == b.size() - 1, b[i]);
      if (gap != 0 && (i % gap) == 0) drive(0, 0, 0, 8'hEE);
    end
    drive(0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0; cfg = 16'hA55A;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare_all();
    rst_ni = 1;
    @(negedge clk);
    compare_all();
    drive(0, 0, 0, 8'h00);

    cur_req = "R2_R3_R4_R5";   // matching packet, back to back
    pkt({8'h11, 8'h22, 8'hA5, 8'h5A, 8'h33, 8'h44, 8'h01, 8'h02, 8'h03, 8'h04}, 0);

    cur_req = "R6";            // field mismatch in last field byte
    pkt({8'h11, 8'h22, 8'hA5, 8'h5B, 8'h33, 8'h44, 8'h05, 8'h06, 8'h07}, 0);

    cur_req = "R3";            // bytes outside field differ, still passes
    pkt({8'hFF, 8'h00, 8'hA5, 8'h5A, 8'hC3, 8'h3C, 8'h08, 8'h09}, 0);
    cur_req = "R3";            // mismatch in first field byte
    pkt({8'h11, 8'h22, 8'h25, 8'h5A, 8'h33, 8'h44, 8'h0A}, 0);

    cur_req = "R11";           // gaps in header and payload
    pkt({8'h10, 8'h20, 8'hA5, 8'h5A, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70}, 2);

    cur_req = "R10";           // exactly header length
    pkt({8'h01, 8'h02, 8'hA5, 8'h5A, 8'h05, 8'h06}, 0);

    cur_req = "R8";            // stray bytes between packets
    drive(1, 0, 0, 8'hAA);
    drive(1, 0, 1, 8'hBB);
    drive(1, 0, 0, 8'hCC);
    drive(0, 0, 0, 8'h00);

    cur_req = "R9";            // restart during header, then during payload
    drive(1, 1, 0, 8'h91);
    drive(1, 0, 0, 8'h92);
    drive(1, 0, 0, 8'h93);
    drive(1, 1, 0, 8'h11);
    drive(1, 0, 0, 8'h22);
    drive(1, 0, 0, 8'hA5);
    drive(1, 0, 0, 8'h5A);
    drive(1, 0, 0, 8'h33);
    drive(1, 0, 0, 8'h44);
    drive(1, 0, 0, 8'hD1);
    drive(1, 0, 0, 8'hD2);
    pkt({8'h77, 8'h66, 8'hA5, 8'h5A, 8'h55, 8'h44, 8'hE1, 8'hE2}, 0);

    cur_req = "R7";            // runts up to and past saturation
    pkt({8'h01}, 0);
    pkt({8'h01, 8'h02}, 0);
    pkt({8'h01, 8'h02, 8'hA5, 8'h5A, 8'h05}, 1);
    for (int n = 0; n < 6; n++) pkt({8'h40, 8'h41, 8'h42}, 0);
    cur_req = "R7_R4";         // traffic still flows after saturation
    pkt({8'h11, 8'h22, 8'hA5, 8'h5A, 8'h33, 8'h44, 8'hF0}, 0);

    repeat (3) drive(0, 0, 0, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule